// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This unit is the arithmetic slice of a 64-bit integer execution pipe. It takes a first operand, a second operand (a register value or a zero-extended 8-bit literal) and a 7-bit function code. One clock later it returns a 64-bit result, an overflow flag and an illegal-function flag.

The function group covers four kinds of operation:
- add and subtract, in 32-bit longword and 64-bit quadword widths;
- scaled add and subtract, where the first operand is first multiplied by 4 or by 8;
- signed and unsigned magnitude compares, and an equality test;
- a byte-lane compare that returns a per-lane mask.

Longword results are formed on the low 32 bits and sign-extended to 64. Four function codes are trapping variants that report signed overflow. Register-file access and the delivery of traps are handled outside this unit.

Top module: `intalu_unit`

## Requirements
- R1: After a cycle with `rst` high, `res` is zero and `ovf` and `illegal` are low, whatever the inputs were.
- R2: Every output reflects the inputs present at the previous rising clock edge (one register stage).
- R3: Code 0x20 gives A+B and 0x29 gives A-B on 64 bits. Code 0x00 gives A+B and 0x09 gives A-B on bits 31:0, and the result is sign-extended from bit 31 into bits 63:32.
- R4: Scaled forms compute (A*4)±B or (A*8)±B. The add codes are 0x02 (×4) and 0x12 (×8) for longword, and 0x22 and 0x32 for quadword. The subtract codes are 0x0b (×4) and 0x1b (×8) for longword, and 0x2b and 0x3b for quadword. Longword scaled results are sign-extended as in R3.
- R5: When `use_lit` is high, operand B is the zero-extended `lit` value and `b_reg` has no effect; otherwise B is `b_reg`.
- R6: The trapping adds 0x40 (longword) and 0x60 (quadword) raise `ovf` exactly when the true signed sum does not fit the width. The sign bit is bit 31 for longword and bit 63 for quadword.
- R7: The trapping subtracts 0x49 (longword) and 0x69 (quadword) raise `ovf` exactly when the true signed difference does not fit the width.
- R8: `ovf` is low for every code other than 0x40, 0x60, 0x49 and 0x69. A trapping code still returns its wrapped result in `res` when it overflows.
- R9: Compares return 1 when true and 0 otherwise. The codes are: 0x2d equal; 0x4d signed less-than; 0x6d signed less-or-equal; 0x1d unsigned less-than; 0x3d unsigned less-or-equal.
- R10: Code 0x0f sets bit i of `res` (i = 0..7) when unsigned byte i of A is greater than or equal to byte i of B. Bits 63:8 are zero.
- R11: Any code not listed in R3 to R10 raises `illegal`, gives a zero `res` and keeps `ovf` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 64 | Operand A |
| b_reg | input | 64 | Register form of operand B |
| lit | input | 8 | Literal form of operand B |
| use_lit | input | 1 | Select the literal as operand B |
| func | input | 7 | Function code |
| res | output | 64 | Registered result |
| ovf | output | 1 | Registered signed-overflow flag |
| illegal | output | 1 | Registered illegal-function flag |

## Verification
Directed vectors cover specific boundaries:
- Longword sums that cross bit 31 show whether sign extension comes from bit 31 or from the 64-bit carry.
- Operand pairs at the signed extremes show whether the add and subtract overflow rules are told apart.
- Negative-against-positive compares show whether signed and unsigned ordering are kept separate.
- Mixed byte lanes, including equal bytes, show whether the byte-lane compare is per lane and inclusive.
- Literal vectors with a busy `b_reg` show that the operand select works.

Several hundred random vectors across all legal and some illegal codes are then checked against a behavioural model that uses widened arithmetic.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  typedef enum logic [2:0] {K_ADD, K_SUB, K_CMP, K_BGE, K_BAD} kind_t;
  typedef enum logic [2:0] {C_EQ, C_SLT, C_SLE, C_ULT, C_ULE} cmp_t;
  typedef struct packed {
    kind_t      kind;
    logic       quad;
    logic [1:0] shamt;
    logic       trap;
    cmp_t       cmp;
  } ctl_t;
endpackage

// File: rtl/intalu_decode.sv
module intalu_decode
  import intalu_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic [FUNC_W-1:0] func,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '{kind: K_BAD, quad: 1'b0, shamt: 2'd0, trap: 1'b0, cmp: C_EQ};
    case (func)
      7'h00: ctl.kind = K_ADD;
      7'h20: begin ctl.kind = K_ADD; ctl.quad = 1'b1; end
      7'h02: begin ctl.kind = K_ADD; ctl.shamt = 2'd2; end
      7'h12: begin ctl.kind = K_ADD; ctl.shamt = 2'd3; end
      7'h22: begin ctl.kind = K_ADD; ctl.quad = 1'b1; ctl.shamt = 2'd2; end
      7'h32: begin ctl.kind = K_ADD; ctl.quad = 1'b1; ctl.shamt = 2'd3; end
      7'h40: begin ctl.kind = K_ADD; ctl.trap = 1'b1; end
      7'h60: begin ctl.kind = K_ADD; ctl.quad = 1'b1; ctl.trap = 1'b1; end
      7'h09: ctl.kind = K_SUB;
      7'h29: begin ctl.kind = K_SUB; ctl.quad = 1'b1; end
      7'h0b: begin ctl.kind = K_SUB; ctl.shamt = 2'd2; end
      7'h1b: begin ctl.kind = K_SUB; ctl.shamt = 2'd3; end
      7'h2b: begin ctl.kind = K_SUB; ctl.quad = 1'b1; ctl.shamt = 2'd2; end
      7'h3b: begin ctl.kind = K_SUB; ctl.quad = 1'b1; ctl.shamt = 2'd3; end
      7'h49: begin ctl.kind = K_SUB; ctl.trap = 1'b1; end
      7'h69: begin ctl.kind = K_SUB; ctl.quad = 1'b1; ctl.trap = 1'b1; end
      7'h2d: begin ctl.kind = K_CMP; ctl.cmp = C_EQ;  end
      7'h4d: begin ctl.kind = K_CMP; ctl.cmp = C_SLT; end
      7'h6d: begin ctl.kind = K_CMP; ctl.cmp = C_SLE; end
      7'h1d: begin ctl.kind = K_CMP; ctl.cmp = C_ULT; end
      7'h3d: begin ctl.kind = K_CMP; ctl.cmp = C_ULE; end
      7'h0f: ctl.kind = K_BGE;
      default: ctl.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/intalu_arith.sv
module intalu_arith
  import intalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  ctl_t              ctl,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_raw
);
  localparam int EXT_W = DATA_W - HALF_W;

  logic [DATA_W-1:0] a_sc;
  logic [DATA_W-1:0] raw;
  logic              sub;
  logic              sa, sb, sr;

  always_comb begin
    a_sc = a << ctl.shamt;
    sub  = (ctl.kind == K_SUB);
    raw  = sub ? (a_sc - b) : (a_sc + b);
    if (ctl.quad) begin
      sum = raw;
      sa  = a_sc[DATA_W-1];
      sb  = b[DATA_W-1];
      sr  = raw[DATA_W-1];
    end else begin
      sum = {{EXT_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      sa  = a_sc[HALF_W-1];
      sb  = b[HALF_W-1];
      sr  = raw[HALF_W-1];
    end
    ovf_raw = ctl.trap && (sub ? (sa != sb) : (sa == sb)) && (sr != sa);
  end
endmodule

// File: rtl/intalu_cmp.sv
module intalu_cmp
  import intalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  input  cmp_t                     sel,
  output logic                     flag,
  output logic [DATA_W/LANE_W-1:0] lane_ge
);
  localparam int LANES = DATA_W / LANE_W;

  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    case (sel)
      C_EQ:    flag = eq;
      C_SLT:   flag = slt;
      C_SLE:   flag = slt | eq;
      C_ULT:   flag = ult;
      C_ULE:   flag = ult | eq;
      default: flag = 1'b0;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_ge[i] = (a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/intalu_unit.sv
module intalu_unit
  import intalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8,
  parameter int FUNC_W = 7,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [LIT_W-1:0]  lit,
  input  logic              use_lit,
  input  logic [FUNC_W-1:0] func,
  output logic [DATA_W-1:0] res,
  output logic              ovf,
  output logic              illegal
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LANES  = DATA_W / LANE_W;

  ctl_t              ctl;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W-1:0] sum;
  logic              ovf_raw;
  logic              cmp_flag;
  logic [LANES-1:0]  lane_ge;
  logic [DATA_W-1:0] res_d;
  logic              ovf_d, ill_d;

  assign b_op = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : b_reg;

  intalu_decode #(.FUNC_W(FUNC_W)) u_dec (.func(func), .ctl(ctl));

  intalu_arith #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_arith (
    .a(a_in), .b(b_op), .ctl(ctl), .sum(sum), .ovf_raw(ovf_raw));

  intalu_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a(a_in), .b(b_op), .sel(ctl.cmp), .flag(cmp_flag), .lane_ge(lane_ge));

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    ill_d = 1'b0;
    case (ctl.kind)
      K_ADD, K_SUB: begin res_d = sum; ovf_d = ovf_raw; end
      K_CMP:        res_d = {{(DATA_W-1){1'b0}}, cmp_flag};
      K_BGE:        res_d = {{(DATA_W-LANES){1'b0}}, lane_ge};
      default:      ill_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      ovf     <= 1'b0;
      illegal <= 1'b0;
    end else begin
      res     <= res_d;
      ovf     <= ovf_d;
      illegal <= ill_d;
    end
  end
endmodule

// File: rtl/intalu_chk.sv
module intalu_chk #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [FUNC_W-1:0] func,
  input logic [DATA_W-1:0] res,
  input logic              ovf,
  input logic              illegal
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic trap_code(input logic [FUNC_W-1:0] f);
    return (f == 7'h40) || (f == 7'h60) || (f == 7'h49) || (f == 7'h69);
  endfunction

  function automatic logic long_code(input logic [FUNC_W-1:0] f);
    return (f == 7'h00) || (f == 7'h02) || (f == 7'h12) || (f == 7'h09) ||
           (f == 7'h0b) || (f == 7'h1b) || (f == 7'h40) || (f == 7'h49);
  endfunction

  function automatic logic cmp_code(input logic [FUNC_W-1:0] f);
    return (f == 7'h2d) || (f == 7'h4d) || (f == 7'h6d) || (f == 7'h1d) || (f == 7'h3d);
  endfunction

  p_sext_r3: assert property (@(posedge clk) disable iff (rst)
    long_code(func) |=> (res[DATA_W-1:HALF_W] == {HALF_W{res[HALF_W-1]}}));

  p_no_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    !trap_code(func) |=> !ovf);

  p_cmp_bool_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_code(func) |=> (res[DATA_W-1:1] == '0));

  p_lane_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (func == 7'h0f) |=> (res[DATA_W-1:8] == '0));

  p_illegal_zero_r11: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (res == '0 && !ovf));

  p_illegal_flag_r11: assert property (@(posedge clk) disable iff (rst)
    (trap_code(func) || long_code(func) || cmp_code(func)) |=> !illegal);
endmodule

bind intalu_unit intalu_chk #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rst(rst), .func(func), .res(res), .ovf(ovf), .illegal(illegal));

// File: tb/sim_intalu_unit.sv
`timescale 1ns/1ps
module sim_intalu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a_in = '0, b_reg = '0;
  logic [7:0]  lit = '0;
  logic        use_lit = 1'b0;
  logic [6:0]  func = 7'h00;
  logic [63:0] res;
  logic        ovf, illegal;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  intalu_unit u0 (.clk(clk), .rst(rst), .a_in(a_in), .b_reg(b_reg), .lit(lit),
                  .use_lit(use_lit), .func(func), .res(res), .ovf(ovf), .illegal(illegal));

  localparam logic [6:0] CODES [22] = '{7'h00, 7'h20, 7'h09, 7'h29, 7'h02, 7'h12, 7'h22,
    7'h32, 7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h40, 7'h60, 7'h49, 7'h69, 7'h2d, 7'h4d, 7'h6d,
    7'h1d, 7'h3d, 7'h0f};

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [6:0] f, output logic [63:0] r,
                                output logic o, output logic il);
    logic signed [64:0] wide;
    longint             l;
    logic [63:0]        m;
    int                 k;
    r = '0; o = 1'b0; il = 1'b0;
    m = 64'd1;
    if (f inside {7'h02, 7'h22, 7'h0b, 7'h2b}) m = 64'd4;
    if (f inside {7'h12, 7'h32, 7'h1b, 7'h3b}) m = 64'd8;
    case (f)
      7'h20, 7'h22, 7'h32, 7'h60: r = a * m + b;
      7'h29, 7'h2b, 7'h3b, 7'h69: r = a * m - b;
      7'h00, 7'h02, 7'h12, 7'h40: begin
        r = a * m + b; r = 64'($signed(r[31:0]));
      end
      7'h09, 7'h0b, 7'h1b, 7'h49: begin
        r = a * m - b; r = 64'($signed(r[31:0]));
      end
      7'h2d: r = 64'(a == b);
      7'h4d: r = 64'($signed(a) < $signed(b));
      7'h6d: r = 64'(!($signed(b) < $signed(a)));
      7'h1d: r = 64'(a < b);
      7'h3d: r = 64'(!(b < a));
      7'h0f: for (k = 0; k < 8; k++) r[k] = (a[8*k +: 8] >= b[8*k +: 8]);
      default: il = 1'b1;
    endcase
    if (f == 7'h40 || f == 7'h49) begin
      l = longint'($signed(a[31:0]));
      if (f == 7'h40) l = l + longint'($signed(b[31:0]));
      else            l = l - longint'($signed(b[31:0]));
      o = (l > 64'sd2147483647) || (l < -64'sd2147483648);
    end
    if (f == 7'h60 || f == 7'h69) begin
      wide = (f == 7'h60) ? ($signed({a[63], a}) + $signed({b[63], b}))
                          : ($signed({a[63], a}) - $signed({b[63], b}));
      o = (wide[64] != wide[63]);
    end
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] br, input logic [7:0] lt,
                     input logic ul, input logic [6:0] f, input string tag);
    logic [63:0] er, bop;
    logic        eo, ei;
    a_in = a; b_reg = br; lit = lt; use_lit = ul; func = f;
    bop = ul ? {56'd0, lt} : br;
    model(a, bop, f, er, eo, ei);
    @(negedge clk);
    checks++;
    if (res !== er || ovf !== eo || illegal !== ei) begin
      errors++;
      $display("FAIL %s func=%h: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
               tag, f, res, ovf, illegal, er, eo, ei);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    func = 7'h7f; a_in = '1; b_reg = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (res !== '0 || ovf !== 1'b0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got res=%h ovf=%b ill=%b, expected 0 0 0", res, ovf, illegal);
    end
    rst = 1'b0;
    // R2 R3: one-cycle latency, longword sign extension across bit 31
    run(64'h0000_0000_7fff_ffff, 64'd1, 8'd0, 1'b0, 7'h00, "R3 addl");
    run(64'h1234_5678_9abc_def0, 64'h1111_1111_1111_1111, 8'd0, 1'b0, 7'h20, "R3 addq");
    run(64'd0, 64'd1, 8'd0, 1'b0, 7'h09, "R3 subl");
    run(64'd5, 64'd9, 8'd0, 1'b0, 7'h29, "R3 subq");
    // R4 scaled forms
    run(64'h2000_0000, 64'd3, 8'd0, 1'b0, 7'h02, "R4 s4addl");
    run(64'd10, 64'd100, 8'd0, 1'b0, 7'h3b, "R4 s8subq");
    run(64'h0fff_ffff_ffff_ffff, 64'd7, 8'd0, 1'b0, 7'h32, "R4 s8addq");
    // R5 literal operand with busy register value
    run(64'd1000, 64'hdead_beef_dead_beef, 8'hff, 1'b1, 7'h20, "R5 literal");
    // R6 R8 trapping adds
    run(64'h7fff_ffff, 64'd1, 8'd0, 1'b0, 7'h40, "R6 addlv overflow");
    run(64'h7fff_ffff_ffff_ffff, 64'd1, 8'd0, 1'b0, 7'h60, "R6 addqv overflow");
    run(64'hffff_ffff_ffff_ffff, 64'd1, 8'd0, 1'b0, 7'h60, "R6 addqv mixed signs");
    // R7 trapping subtracts
    run(64'h8000_0000, 64'd1, 8'd0, 1'b0, 7'h49, "R7 sublv overflow");
    run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'd0, 1'b0, 7'h69, "R7 subqv same sign");
    run(64'h0, 64'h8000_0000_0000_0000, 8'd0, 1'b0, 7'h69, "R7 subqv overflow");
    // R8 non-trapping code that would overflow
    run(64'h7fff_ffff_ffff_ffff, 64'd1, 8'd0, 1'b0, 7'h20, "R8 addq no flag");
    // R9 compares
    run(64'hffff_ffff_ffff_ffff, 64'd1, 8'd0, 1'b0, 7'h4d, "R9 cmplt signed");
    run(64'hffff_ffff_ffff_ffff, 64'd1, 8'd0, 1'b0, 7'h1d, "R9 cmpult unsigned");
    run(64'd42, 64'd42, 8'd0, 1'b0, 7'h2d, "R9 cmpeq");
    run(64'd42, 64'd42, 8'd0, 1'b0, 7'h6d, "R9 cmple equal");
    run(64'd43, 64'd42, 8'd0, 1'b0, 7'h3d, "R9 cmpule false");
    // R10 byte-lane compare
    run(64'h00ff_1080_7f01_ff00, 64'h0100_1081_7e01_fe00, 8'd0, 1'b0, 7'h0f, "R10 lanes");
    // R11 illegal codes
    run(64'd5, 64'd6, 8'd0, 1'b0, 7'h7f, "R11 illegal");
    run(64'd5, 64'd6, 8'd0, 1'b0, 7'h01, "R11 illegal");
    // random sweep across all legal codes and a few illegal ones
    for (int i = 0; i < 400; i++) begin
      logic [6:0] f;
      f = (i % 10 == 9) ? 7'($urandom) : CODES[$urandom_range(0, 21)];
      run({$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom), 1'($urandom), f,
          "R3-sweep random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule